// File: doc/BRIEF.md
# Slot-Based Flexible Power Sequencer

This block switches a set of power rails (regulator enables, GPIO enables, a clock enable) on and off in an ordered sequence. Three master timers each watch one enable source. The source can be either of two hardware pins or a software bit. Whenever the selected level changes, in either direction, the master issues eight slot events. The events are spaced by a programmable period counted in microsecond ticks from an external prescaler pulse.

Each rail subscribes to one master and holds its own power-up slot and power-down slot. A rail can instead follow a software bit directly. On a power-down sequence, the master's inactive-state setting decides what happens to each rail at its slot:
- sleep turns the rail off;
- low power raises the rail's low-power flag and leaves the rail on;
- any other code leaves the rail unchanged.

A power-OK output combines the good signals of the rails chosen by a mask. Configuration is loaded through a single-cycle register write strobe. Every pin is a plain level or strobe: no data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. The hardware enable pins are assumed synchronous to `clk`.

Top module: `pwr_slot_sequencer`

## Requirements
- R1: Bits [1:0] of master register m (address m, m=0..2) select its source. 0 selects hw_en[0], 1 selects hw_en[1], 2 selects software bit m of address 4, and 3 holds the source inactive. A pin that is not selected has no effect on that master.
- R2: A change of the selected level starts a sequence. seq_busy[m] is high from the next cycle and falls on the edge that issues the eighth slot event. With a tick every cycle, that edge comes 8·P cycles after the start.
- R3: Bits [4:2] of a master register form a code. The slot period is P = 40 << code microsecond ticks. The first event comes one period after the start, and slot counting advances only in cycles with us_tick high.
- R4: Slave register i is at address 8+i. Its fields are:
  - [1:0]: source, where 0..2 is a master and 3 is a software bit;
  - [4:2]: up slot;
  - [7:5]: down slot.

  At its up-slot event in a power-up sequence, rail_en[i] goes to 1 and rail_lp[i] goes to 0.
- R5: Bits [6:5] of a master register hold the inactive state. With value 0 (sleep), a bound rail gets rail_en=0 and rail_lp=0 at its down-slot event.
- R6: With inactive state 1 (low power), a bound rail that is on gets rail_lp=1 at its down-slot event, and rail_en stays 1.
- R7: With inactive state 2 or 3, a power-down sequence leaves rail_en and rail_lp unchanged.
- R8: A rail with source 3 drives rail_en[i] from bit i of address 5, registered, so it follows the second rising edge after the write. rail_lp[i] is 0 and master events are ignored.
- R9: A level change during a running sequence abandons it. The opposite sequence starts again from slot 0, and events of the abandoned sequence never reach the rails.
- R10: pok is high exactly when every rail whose bit is set in the mask at address 6 has rail_good high.
- R11: After reset all masters and slaves have source 3 and all software bits and the mask are 0. rail_en, rail_lp and seq_busy are 0, and pok is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| hw_en | input | 2 | Hardware enable pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| rail_good | input | NUM_SLAVES | Per-rail good indication |
| rail_en | output | NUM_SLAVES | Per-rail enable |
| rail_lp | output | NUM_SLAVES | Per-rail low-power flag |
| seq_busy | output | NUM_MASTERS | Master sequence running |
| pok | output | 1 | Aggregate power-OK |

## Verification
Each timer's slot counter and period counter show up at the ports as the exact edge on which a rail switches. A counter that is off by one moves that switch one cycle, or one whole period, from the computed time. The bench therefore samples every rail transition on both sides of its edge. A wrong restart state (stale slot, wrong direction) shows within one period of the abandoning level change, as a rail that switches when it should not or a busy flag that falls early. A wrong inactive-state decode shows at the down-slot edge, as an enable or low-power flag with the wrong value.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int SLOT_W    = 3;
  localparam int NUM_SLOTS = 1 << SLOT_W;
  localparam int CODE_W    = 3;
  localparam int SRC_W     = 2;
  localparam int HW_PINS   = 2;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;

  localparam logic [ADDR_W-1:0] A_MSW = 4'd4;
  localparam logic [ADDR_W-1:0] A_SSW = 4'd5;
  localparam logic [ADDR_W-1:0] A_POK = 4'd6;
  localparam int                A_SLV = 8;

  localparam logic [1:0] INACT_SLEEP  = 2'd0;
  localparam logic [1:0] INACT_LOWPWR = 2'd1;

  localparam logic [SRC_W-1:0] SRC_OFF = 2'd3;

  typedef struct packed {
    logic [SLOT_W-1:0] dn_slot;
    logic [SLOT_W-1:0] up_slot;
    logic [SRC_W-1:0]  src;
  } slv_cfg_t;
endpackage

// File: rtl/pss_cfg_regs.sv
module pss_cfg_regs
  import pss_pkg::*;
#(
  parameter int NUM_MASTERS = 3,
  parameter int NUM_SLAVES  = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [NUM_MASTERS-1:0][SRC_W-1:0]  m_src,
  output logic [NUM_MASTERS-1:0][CODE_W-1:0] m_code,
  output logic [NUM_MASTERS-1:0][1:0]        m_inact,
  output logic [NUM_MASTERS-1:0]             m_sw,
  output slv_cfg_t [NUM_SLAVES-1:0]          s_cfg,
  output logic [NUM_SLAVES-1:0]              s_sw,
  output logic [NUM_SLAVES-1:0]              pok_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_src    <= {NUM_MASTERS{SRC_OFF}};
      m_code   <= '0;
      m_inact  <= '0;
      m_sw     <= '0;
      s_cfg    <= {NUM_SLAVES{slv_cfg_t'({6'd0, SRC_OFF})}};
      s_sw     <= '0;
      pok_mask <= '0;
    end else if (wr_en) begin
      for (int m = 0; m < NUM_MASTERS; m++) begin
        if (wr_addr == ADDR_W'(m)) begin
          m_src[m]   <= wr_data[1:0];
          m_code[m]  <= wr_data[4:2];
          m_inact[m] <= wr_data[6:5];
        end
      end
      for (int s = 0; s < NUM_SLAVES; s++) begin
        if (wr_addr == ADDR_W'(A_SLV + s)) s_cfg[s] <= slv_cfg_t'(wr_data);
      end
      if (wr_addr == A_MSW) m_sw     <= wr_data[NUM_MASTERS-1:0];
      if (wr_addr == A_SSW) s_sw     <= wr_data[NUM_SLAVES-1:0];
      if (wr_addr == A_POK) pok_mask <= wr_data[NUM_SLAVES-1:0];
    end
  end
endmodule

// File: rtl/pss_master_timer.sv
module pss_master_timer
  import pss_pkg::*;
#(
  parameter int BASE_US = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               us_tick,
  input  logic [HW_PINS-1:0] hw_en,
  input  logic               sw_en,
  input  logic [SRC_W-1:0]   src,
  input  logic [CODE_W-1:0]  code,
  output logic               busy,
  output logic               ev_fire,
  output logic               ev_dir,
  output logic [SLOT_W-1:0]  ev_slot
);
  localparam int MAX_P = BASE_US << ((1 << CODE_W) - 1);
  localparam int CNT_W = $clog2(MAX_P + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic             lvl, lvl_q, edge_seen, busy_q, dir_q, at_end;
  logic [CNT_W-1:0] cnt_q, last_cnt;
  logic [SLOT_W-1:0] slot_q;

  always_comb begin
    case (src)
      2'd0:    lvl = hw_en[0];
      2'd1:    lvl = hw_en[1];
      2'd2:    lvl = sw_en;
      default: lvl = 1'b0;
    endcase
  end

  assign edge_seen = lvl ^ lvl_q;
  assign last_cnt  = CNT_W'((BASE_US << code) - 1);
  assign at_end    = (cnt_q >= last_cnt);
  assign ev_fire   = busy_q && us_tick && at_end && !edge_seen;
  assign ev_dir    = dir_q;
  assign ev_slot   = slot_q;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
    end else begin
      lvl_q <= lvl;
      if (edge_seen) begin
        busy_q <= 1'b1;
        dir_q  <= lvl;
        cnt_q  <= '0;
        slot_q <= '0;
      end else if (busy_q && us_tick) begin
        if (at_end) begin
          cnt_q  <= '0;
          slot_q <= slot_q + 1'b1;
          if (slot_q == LAST_SLOT) busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(ev_fire && slot_q == LAST_SLOT));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> (busy_q && slot_q == '0 && cnt_q == '0 && dir_q == lvl_q));

  // R3
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!us_tick && !edge_seen) |=> ($stable(slot_q) && $stable(cnt_q)));
endmodule

// File: rtl/pss_slave_ctl.sv
module pss_slave_ctl
  import pss_pkg::*;
#(
  parameter int NUM_MASTERS = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  slv_cfg_t                           cfg,
  input  logic                               sw_bit,
  input  logic [NUM_MASTERS-1:0]             ev_fire,
  input  logic [NUM_MASTERS-1:0]             ev_dir,
  input  logic [NUM_MASTERS-1:0][SLOT_W-1:0] ev_slot,
  input  logic [NUM_MASTERS-1:0][1:0]        inact,
  output logic                               en,
  output logic                               lp
);
  logic              sel_fire, sel_dir, sw_mode, up_hit, dn_hit;
  logic [SLOT_W-1:0] sel_slot;
  logic [1:0]        sel_inact;
  logic              en_q, lp_q;

  always_comb begin
    sel_fire  = 1'b0;
    sel_dir   = 1'b0;
    sel_slot  = '0;
    sel_inact = INACT_SLEEP;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (int'(cfg.src) == m) begin
        sel_fire  = ev_fire[m];
        sel_dir   = ev_dir[m];
        sel_slot  = ev_slot[m];
        sel_inact = inact[m];
      end
    end
  end

  assign sw_mode = int'(cfg.src) >= NUM_MASTERS;
  assign up_hit  = !sw_mode && sel_fire &&  sel_dir && (sel_slot == cfg.up_slot);
  assign dn_hit  = !sw_mode && sel_fire && !sel_dir && (sel_slot == cfg.dn_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      lp_q <= 1'b0;
    end else if (sw_mode) begin
      en_q <= sw_bit;
      lp_q <= 1'b0;
    end else if (up_hit) begin
      en_q <= 1'b1;
      lp_q <= 1'b0;
    end else if (dn_hit) begin
      case (sel_inact)
        INACT_SLEEP: begin
          en_q <= 1'b0;
          lp_q <= 1'b0;
        end
        INACT_LOWPWR: lp_q <= en_q;
        default: ;
      endcase
    end
  end

  assign en = en_q;
  assign lp = lp_q;

  // R6
  lp_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    lp_q |-> en_q);

  // R7
  keep_state_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_hit && sel_inact != INACT_SLEEP && sel_inact != INACT_LOWPWR)
      |=> ($stable(en_q) && $stable(lp_q)));

  // R5
  sleep_off_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_hit && sel_inact == INACT_SLEEP) |=> (!en_q && !lp_q));
endmodule

// File: rtl/pwr_slot_sequencer.sv
module pwr_slot_sequencer
  import pss_pkg::*;
#(
  parameter int NUM_MASTERS = 3,
  parameter int NUM_SLAVES  = 6,
  parameter int BASE_US     = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   us_tick,
  input  logic [1:0]             hw_en,
  input  logic                   wr_en,
  input  logic [3:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [NUM_SLAVES-1:0]  rail_good,
  output logic [NUM_SLAVES-1:0]  rail_en,
  output logic [NUM_SLAVES-1:0]  rail_lp,
  output logic [NUM_MASTERS-1:0] seq_busy,
  output logic                   pok
);
  logic [NUM_MASTERS-1:0][SRC_W-1:0]  m_src;
  logic [NUM_MASTERS-1:0][CODE_W-1:0] m_code;
  logic [NUM_MASTERS-1:0][1:0]        m_inact;
  logic [NUM_MASTERS-1:0]             m_sw;
  slv_cfg_t [NUM_SLAVES-1:0]          s_cfg;
  logic [NUM_SLAVES-1:0]              s_sw, pok_mask;

  logic [NUM_MASTERS-1:0]             ev_fire, ev_dir;
  logic [NUM_MASTERS-1:0][SLOT_W-1:0] ev_slot;

  pss_cfg_regs #(.NUM_MASTERS(NUM_MASTERS), .NUM_SLAVES(NUM_SLAVES)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .m_src(m_src), .m_code(m_code), .m_inact(m_inact), .m_sw(m_sw),
    .s_cfg(s_cfg), .s_sw(s_sw), .pok_mask(pok_mask)
  );

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    pss_master_timer #(.BASE_US(BASE_US)) tmr_i (
      .clk(clk), .rst(rst), .us_tick(us_tick), .hw_en(hw_en),
      .sw_en(m_sw[m]), .src(m_src[m]), .code(m_code[m]),
      .busy(seq_busy[m]), .ev_fire(ev_fire[m]), .ev_dir(ev_dir[m]),
      .ev_slot(ev_slot[m])
    );
  end

  for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_slv
    pss_slave_ctl #(.NUM_MASTERS(NUM_MASTERS)) slv_i (
      .clk(clk), .rst(rst), .cfg(s_cfg[s]), .sw_bit(s_sw[s]),
      .ev_fire(ev_fire), .ev_dir(ev_dir), .ev_slot(ev_slot), .inact(m_inact),
      .en(rail_en[s]), .lp(rail_lp[s])
    );
  end

  assign pok = &(rail_good | ~pok_mask);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (rail_en == '0 && rail_lp == '0 && seq_busy == '0 && pok));
endmodule

// File: tb/pwr_slot_sequencer_tb_top.sv
module pwr_slot_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int NS = 6;
  localparam int P0 = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          us_tick = 1'b1;
  logic [1:0]    hw_en = 2'b00;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [NS-1:0] rail_good = '1;
  logic [NS-1:0] rail_en, rail_lp;
  logic [NM-1:0] seq_busy;
  logic          pok;

  int total = 0;
  int bad = 0;
  int t = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_slot_sequencer #(.NUM_MASTERS(NM), .NUM_SLAVES(NS), .BASE_US(40)) dut_i (
    .clk(clk), .rst(rst), .us_tick(us_tick), .hw_en(hw_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rail_good(rail_good),
    .rail_en(rail_en), .rail_lp(rail_lp), .seq_busy(seq_busy), .pok(pok)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
    end
  endtask

  task automatic go(input int k);
    while (t < k) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; hw_en = 2'b00; us_tick = 1'b1; rail_good = '1; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    chk("R11 rail_en", int'(rail_en), 0);
    chk("R11 rail_lp", int'(rail_lp), 0);
    chk("R11 busy", int'(seq_busy), 0);
    chk("R11 pok", int'(pok), 1);
    hw_en = 2'b11;
    repeat (4) @(negedge clk);
    chk("R11 src3 masters idle", int'(seq_busy), 0);
    hw_en = 2'b00;
  endtask

  task automatic test_source_and_up();
    do_reset();
    wr(4'd0, 8'h01);
    wr(4'd8, 8'hA8);
    wr(4'd9, 8'hE0);
    hw_en[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 unselected pin ignored", int'(seq_busy[0]), 0);
    chk("R1 unselected pin rail", int'(rail_en[1:0]), 0);
    hw_en[0] = 1'b0;
    @(negedge clk);
    hw_en[1] = 1'b1; t = 0;
    go(1);      chk("R2 busy raised", int'(seq_busy[0]), 1);
    go(P0);     chk("R3 before first event", int'(rail_en[1]), 0);
    go(P0+1);   chk("R3 first event one period", int'(rail_en[1]), 1);
    go(3*P0);   chk("R4 before up slot 2", int'(rail_en[0]), 0);
    go(3*P0+1); chk("R4 at up slot 2", int'(rail_en[0]), 1);
    chk("R4 lp low after up", int'(rail_lp[1:0]), 0);
    go(8*P0);   chk("R2 busy before last event", int'(seq_busy[0]), 1);
    go(8*P0+1); chk("R2 busy after last event", int'(seq_busy[0]), 0);
  endtask

  task automatic test_sleep_down();
    do_reset();
    wr(4'd0, 8'h01);
    wr(4'd8, 8'hA8);
    wr(4'd9, 8'hE0);
    hw_en[1] = 1'b1; t = 0;
    go(8*P0+2);
    hw_en[1] = 1'b0; t = 0;
    go(6*P0);   chk("R5 before down slot 5", int'(rail_en[0]), 1);
    go(6*P0+1); chk("R5 sleep at down slot 5", int'(rail_en[0]), 0);
    chk("R5 other rail still on", int'(rail_en[1]), 1);
    go(8*P0);   chk("R5 before down slot 7", int'(rail_en[1]), 1);
    go(8*P0+1); chk("R5 sleep at down slot 7", int'(rail_en[1]), 0);
    chk("R5 lp stays low", int'(rail_lp[1:0]), 0);
  endtask

  task automatic test_low_power();
    do_reset();
    wr(4'd1, 8'h26);
    wr(4'd10, 8'h65);
    wr(4'd4, 8'h02); t = 1;
    go(2*2*P0+1); chk("R3 code1 before up slot 1", int'(rail_en[2]), 0);
    go(2*2*P0+2); chk("R3 code1 at up slot 1", int'(rail_en[2]), 1);
    go(8*2*P0+1); chk("R2 code1 busy", int'(seq_busy[1]), 1);
    go(8*2*P0+2); chk("R2 code1 busy done", int'(seq_busy[1]), 0);
    wr(4'd4, 8'h00); t = 1;
    go(4*2*P0+1); chk("R6 before down slot 3", int'(rail_lp[2]), 0);
    go(4*2*P0+2); chk("R6 low power flag", int'(rail_lp[2]), 1);
    chk("R6 rail kept on", int'(rail_en[2]), 1);
  endtask

  task automatic test_keep();
    do_reset();
    wr(4'd2, 8'h40);
    wr(4'd11, 8'h02);
    hw_en[0] = 1'b1; t = 0;
    go(9*P0); chk("R4 master2 up", int'(rail_en[3]), 1);
    hw_en[0] = 1'b0; t = 0;
    go(9*P0);
    chk("R7 enable unchanged", int'(rail_en[3]), 1);
    chk("R7 lp unchanged", int'(rail_lp[3]), 0);
    chk("R7 sequence ran", int'(seq_busy[2]), 0);
  endtask

  task automatic test_sw_slave();
    do_reset();
    wr(4'd0, 8'h00);
    wr(4'd5, 8'h10); t = 1;
    chk("R8 not yet", int'(rail_en[4]), 0);
    go(2); chk("R8 follows sw bit", int'(rail_en[4]), 1);
    hw_en[0] = 1'b1; t = 0;
    go(9*P0);
    hw_en[0] = 1'b0; t = 0;
    go(9*P0);
    chk("R8 master events ignored", int'(rail_en[4]), 1);
    chk("R8 lp zero", int'(rail_lp[4]), 0);
    wr(4'd5, 8'h00); t = 1;
    go(2); chk("R8 follows sw clear", int'(rail_en[4]), 0);
  endtask

  task automatic test_abort();
    do_reset();
    wr(4'd0, 8'h00);
    wr(4'd8, 8'h30);
    wr(4'd9, 8'hC4);
    hw_en[0] = 1'b1; t = 0;
    go(3*P0);
    chk("R9 slot1 rail on", int'(rail_en[1]), 1);
    hw_en[0] = 1'b0; t = 0;
    go(1);      chk("R9 busy on restart", int'(seq_busy[0]), 1);
    go(6*P0);   chk("R9 abandoned up slot 4", int'(rail_en[0]), 0);
    go(7*P0);   chk("R9 restart from slot0 before 6", int'(rail_en[1]), 1);
    go(7*P0+1); chk("R9 restart from slot0 at 6", int'(rail_en[1]), 0);
    go(8*P0);   chk("R9 restarted busy", int'(seq_busy[0]), 1);
    go(8*P0+1); chk("R9 restarted busy end", int'(seq_busy[0]), 0);
  endtask

  task automatic test_pok();
    do_reset();
    wr(4'd6, 8'h05);
    rail_good = '1; #1;
    chk("R10 all good", int'(pok), 1);
    rail_good = 6'b111011; #1;
    chk("R10 masked rail low", int'(pok), 0);
    rail_good = 6'b111101; #1;
    chk("R10 unmasked rail low", int'(pok), 1);
    @(negedge clk);
    wr(4'd6, 8'h00);
    rail_good = '0; #1;
    chk("R10 empty mask", int'(pok), 1);
    @(negedge clk);
  endtask

  task automatic test_tick_hold();
    do_reset();
    wr(4'd0, 8'h00);
    wr(4'd8, 8'h00);
    us_tick = 1'b0;
    hw_en[0] = 1'b1; t = 0;
    go(3*P0);
    chk("R3 no tick busy", int'(seq_busy[0]), 1);
    chk("R3 no tick no event", int'(rail_en[0]), 0);
    us_tick = 1'b1; t = 0;
    go(P0-1); chk("R3 resumed before period", int'(rail_en[0]), 0);
    go(P0);   chk("R3 resumed period done", int'(rail_en[0]), 1);
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_source_and_up();
    test_sleep_down();
    test_low_power();
    test_keep();
    test_sw_slave();
    test_abort();
    test_pok();
    test_tick_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule